// File: doc/BRIEF.md
# Monolithic descriptor payload extractor

This block walks one single-buffer packet descriptor that sits in a word-addressed local memory and turns it into two output streams. A one-cycle `start` pulse hands over the descriptor's word address. The block reads the first and third header words, validates them, then sends any protocol-specific words on a sideband stream and the payload bytes on a data stream that carries byte enables and an end-of-packet flag. A single `done_valid` pulse closes every descriptor. It carries an error code and the return routing the completion path needs: head or tail push, queue manager and queue number.

Memory is little-endian by byte: byte address `a` is lane `a mod 4` of word `a / 4`. The read port answers one cycle after `mem_rd_en`. The payload may start at any byte offset. The extractor shifts bytes across word boundaries so that the first payload byte always leaves in lane 0. Both output streams use ready/valid. While an output beat waits for its ready, no memory read is issued.

Top module: `mono_desc_extract`

## Requirements
- R1: If bits 31:30 of header word 0 are not 2, `done_err` is 1 and no sideband or payload beat is sent.
- R2: A protocol-specific word count (header word 2, bits 29:24) above 32 gives `done_err` 2, unless R1 applies.
- R3: A data offset (word 0, bits 24:16) below H + 4 × count gives `done_err` 3, unless R1 or R2 applies. H is 32 when word 2 bit 31 marks the 16-byte extended block as present and 12 otherwise.
- R4: If offset + length (word 0, bits 15:0) is greater than the smaller of 65536 and parameter `DESC_BYTES`, `done_err` is 4, unless R1 to R3 apply. Error cases stream nothing.
- R5: A valid descriptor sends exactly `count` sideband words in address order. They start at word base+8 when the extended block is present and at base+3 when it is not. When the extended block is present, the padding word at base+3 is never read.
- R6: Payload byte i is taken from byte address 4·base + offset + i. It appears in lane i mod 4 of beat i div 4 for any offset alignment.
- R7: Every payload beat except the last has `pd_keep` = 4'b1111. The last beat, and only that one, has `pd_last` set. Its `pd_keep` is 0001, 0011 or 0111 for length mod 4 = 1, 2, 3, and 1111 for 0.
- R8: A valid descriptor with zero length sends no payload beat and ends with `done_err` 0.
- R9: A beat held back by its ready stays valid with unchanged data, keep and last. No memory read is issued while a beat is valid.
- R10: `done_valid` lasts one cycle. With it, `done_ret_head`, `done_ret_qmgr` and `done_ret_qnum` carry word 2 bits 14, 13:12 and 11:0.
- R11: All sideband words are sent before the first payload beat, and the two valid outputs are never high together.
- R12: After reset, `ps_valid`, `pd_valid`, `done_valid` and `mem_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a descriptor; sampled only when idle |
| start_addr | input | ADDR_W | Word address of descriptor byte 0 |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rd_data | input | 32 | Read data, one cycle after the strobe |
| ps_valid | output | 1 | Sideband word valid |
| ps_ready | input | 1 | Sideband sink ready |
| ps_data | output | 32 | Protocol-specific word |
| pd_valid | output | 1 | Payload beat valid |
| pd_ready | input | 1 | Payload sink ready |
| pd_data | output | 32 | Payload bytes, first byte in lane 0 |
| pd_keep | output | 4 | Byte enables of the beat |
| pd_last | output | 1 | Final payload beat |
| done_valid | output | 1 | Completion pulse |
| done_err | output | 3 | 0 ok, 1 type, 2 count, 3 offset, 4 length |
| done_ret_head | output | 1 | Return to head (1) or tail (0) |
| done_ret_qmgr | output | 2 | Return queue manager |
| done_ret_qnum | output | 12 | Return queue number |

## Verification
Two events can fall in the same cycle. The last payload beat can be held back by ready while the completion would otherwise be due, and the handover from the final sideband word to the first payload read can meet a stalled handshake. The bench provokes both by running descriptors under three ready patterns (always ready, every other cycle, one cycle in three). With offsets unaligned by 1 and 3, the byte shift also crosses the stall points. It judges the results by checking that `done_valid` comes only after the beat flagged last has been accepted, that no sideband word follows a payload beat, and that every stalled beat holds its data while no memory read goes out.

// File: rtl/mde_pkg.sv
package mde_pkg;

  typedef enum logic [2:0] {
    ERR_NONE   = 3'd0,
    ERR_TYPE   = 3'd1,
    ERR_PSCNT  = 3'd2,
    ERR_OFFSET = 3'd3,
    ERR_LENGTH = 3'd4
  } err_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HDR_A, ST_HDR_B, ST_HDR_C, ST_CHECK,
    ST_PS_RD, ST_PS_LAT, ST_PS_OUT,
    ST_PL_PRE, ST_PL_PRE_LAT, ST_PL_RD, ST_PL_LAT, ST_PL_OUT,
    ST_DONE
  } state_e;

  // fields kept from the two header words the block uses
  typedef struct packed {
    logic [1:0]  kind;
    logic [8:0]  off;
    logic [15:0] len;
    logic        ext;
    logic [5:0]  cnt;
    logic        ret_head;
    logic [1:0]  ret_qmgr;
    logic [11:0] ret_qnum;
  } hdr_t;

  localparam logic [1:0] KIND_MONO   = 2'd2;
  localparam int unsigned PS_MAX_WORDS = 32;
  localparam int unsigned SIZE_CAP   = 65536;

endpackage

// File: rtl/mde_hdr_check.sv
module mde_hdr_check
  import mde_pkg::*;
#(
  parameter int unsigned DESC_BYTES = 1024
) (
  input  hdr_t       hdr,
  output err_e       err,
  output logic [3:0] ps_first
);
  localparam int unsigned LIMIT = (DESC_BYTES < SIZE_CAP) ? DESC_BYTES : SIZE_CAP;

  logic [9:0]  min_off;
  logic [16:0] end_byte;
  logic        too_long;

  assign ps_first = hdr.ext ? 4'd8 : 4'd3;
  assign min_off  = (hdr.ext ? 10'd32 : 10'd12) + {2'b00, hdr.cnt, 2'b00};
  assign end_byte = {8'd0, hdr.off} + {1'b0, hdr.len};
  assign too_long = ({15'd0, end_byte} > 32'(LIMIT));

  // lowest code wins
  always_comb begin
    if (hdr.kind != KIND_MONO)                      err = ERR_TYPE;
    else if (32'(hdr.cnt) > PS_MAX_WORDS)           err = ERR_PSCNT;
    else if ({1'b0, hdr.off} < min_off)             err = ERR_OFFSET;
    else if (too_long)                              err = ERR_LENGTH;
    else                                            err = ERR_NONE;
  end
endmodule

// File: rtl/mde_realign.sv
module mde_realign (
  input  logic [31:0] lo_word,
  input  logic [31:0] hi_word,
  input  logic [1:0]  shift,
  input  logic [16:0] remain,
  output logic [31:0] aligned,
  output logic [3:0]  keep,
  output logic        last
);
  logic [63:0] pair;
  logic [63:0] shifted;

  assign pair    = {hi_word, lo_word};
  assign shifted = pair >> {shift, 3'b000};
  assign aligned = shifted[31:0];
  assign last    = (remain <= 17'd4);

  always_comb begin
    if (remain >= 17'd4) keep = 4'b1111;
    else begin
      case (remain[1:0])
        2'd1:    keep = 4'b0001;
        2'd2:    keep = 4'b0011;
        2'd3:    keep = 4'b0111;
        default: keep = 4'b0000;
      endcase
    end
  end
endmodule

// File: rtl/mono_desc_extract.sv
module mono_desc_extract
  import mde_pkg::*;
#(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned DESC_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [31:0]       mem_rd_data,
  output logic              ps_valid,
  input  logic              ps_ready,
  output logic [31:0]       ps_data,
  output logic              pd_valid,
  input  logic              pd_ready,
  output logic [31:0]       pd_data,
  output logic [3:0]        pd_keep,
  output logic              pd_last,
  output logic              done_valid,
  output logic [2:0]        done_err,
  output logic              done_ret_head,
  output logic [1:0]        done_ret_qmgr,
  output logic [11:0]       done_ret_qnum
);
  localparam int unsigned REM_W = 17;

  state_e            state_q, state_d;
  logic [ADDR_W-1:0] base_q, ptr_q, ptr_d;
  logic [26:0]       h0_q;
  logic [21:0]       h2_q;
  logic [5:0]        idx_q, idx_d;
  logic [31:0]       prev_q, prev_d, obuf_q, obuf_d;
  logic [REM_W-1:0]  rem_q, rem_d;
  logic base_en, h0_en, h2_en, ptr_en, idx_en, prev_en, obuf_en, rem_en;

  hdr_t              hdr;
  err_e              err;
  logic [3:0]        ps_first;
  logic [31:0]       aligned;
  logic [3:0]        keep_c;
  logic              last_c;
  logic [ADDR_W-1:0] pl_start;

  assign hdr = '{kind: h0_q[26:25], off: h0_q[24:16], len: h0_q[15:0],
                 ext: h2_q[21], cnt: h2_q[20:15], ret_head: h2_q[14],
                 ret_qmgr: h2_q[13:12], ret_qnum: h2_q[11:0]};

  mde_hdr_check #(.DESC_BYTES(DESC_BYTES)) u_check (
    .hdr(hdr), .err(err), .ps_first(ps_first)
  );

  mde_realign u_align (
    .lo_word(prev_q), .hi_word(mem_rd_data), .shift(hdr.off[1:0]),
    .remain(rem_q), .aligned(aligned), .keep(keep_c), .last(last_c)
  );

  assign pl_start = base_q + ADDR_W'(hdr.off[8:2]);

  // next-state process
  always_comb begin
    state_d   = state_q;
    mem_rd_en = 1'b0;
    mem_addr  = ptr_q;
    base_en = 1'b0; h0_en = 1'b0; h2_en = 1'b0;
    ptr_en  = 1'b0; ptr_d = ptr_q;
    idx_en  = 1'b0; idx_d = idx_q;
    prev_en = 1'b0; prev_d = mem_rd_data;
    obuf_en = 1'b0; obuf_d = mem_rd_data;
    rem_en  = 1'b0; rem_d = rem_q;
    case (state_q)
      ST_IDLE: if (start) begin base_en = 1'b1; state_d = ST_HDR_A; end
      ST_HDR_A: begin
        mem_rd_en = 1'b1; mem_addr = base_q; state_d = ST_HDR_B;
      end
      ST_HDR_B: begin
        mem_rd_en = 1'b1; mem_addr = base_q + ADDR_W'(2);
        h0_en = 1'b1; state_d = ST_HDR_C;
      end
      ST_HDR_C: begin h2_en = 1'b1; state_d = ST_CHECK; end
      ST_CHECK: begin
        ptr_en = 1'b1; ptr_d = base_q + ADDR_W'(ps_first);
        idx_en = 1'b1; idx_d = '0;
        rem_en = 1'b1; rem_d = {1'b0, hdr.len};
        if (err != ERR_NONE)      state_d = ST_DONE;
        else if (hdr.cnt != 6'd0) state_d = ST_PS_RD;
        else if (hdr.len != '0)   state_d = ST_PL_PRE;
        else                      state_d = ST_DONE;
      end
      ST_PS_RD: begin
        mem_rd_en = 1'b1; ptr_en = 1'b1; ptr_d = ptr_q + ADDR_W'(1);
        state_d = ST_PS_LAT;
      end
      ST_PS_LAT: begin
        obuf_en = 1'b1; idx_en = 1'b1; idx_d = idx_q + 6'd1;
        state_d = ST_PS_OUT;
      end
      ST_PS_OUT: if (ps_ready) begin
        if (idx_q != hdr.cnt)   state_d = ST_PS_RD;
        else if (hdr.len != '0) state_d = ST_PL_PRE;
        else                    state_d = ST_DONE;
      end
      ST_PL_PRE: begin
        mem_rd_en = 1'b1; mem_addr = pl_start;
        ptr_en = 1'b1; ptr_d = pl_start + ADDR_W'(1);
        state_d = ST_PL_PRE_LAT;
      end
      ST_PL_PRE_LAT: begin prev_en = 1'b1; state_d = ST_PL_RD; end
      ST_PL_RD: begin
        mem_rd_en = 1'b1; ptr_en = 1'b1; ptr_d = ptr_q + ADDR_W'(1);
        state_d = ST_PL_LAT;
      end
      ST_PL_LAT: begin
        obuf_en = 1'b1; obuf_d = aligned; prev_en = 1'b1;
        state_d = ST_PL_OUT;
      end
      ST_PL_OUT: if (pd_ready) begin
        rem_en = 1'b1;
        rem_d  = last_c ? '0 : REM_W'(rem_q - REM_W'(4));
        state_d = last_c ? ST_DONE : ST_PL_RD;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      h0_q    <= '0;
      h2_q    <= '0;
      ptr_q   <= '0;
      idx_q   <= '0;
      prev_q  <= '0;
      obuf_q  <= '0;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      if (base_en) base_q <= start_addr;
      if (h0_en)   h0_q   <= {mem_rd_data[31:30], mem_rd_data[24:0]};
      if (h2_en)   h2_q   <= {mem_rd_data[31], mem_rd_data[29:24], mem_rd_data[14:0]};
      if (ptr_en)  ptr_q  <= ptr_d;
      if (idx_en)  idx_q  <= idx_d;
      if (prev_en) prev_q <= prev_d;
      if (obuf_en) obuf_q <= obuf_d;
      if (rem_en)  rem_q  <= rem_d;
    end
  end

  assign ps_valid      = (state_q == ST_PS_OUT);
  assign pd_valid      = (state_q == ST_PL_OUT);
  assign done_valid    = (state_q == ST_DONE);
  assign ps_data       = obuf_q;
  assign pd_data       = obuf_q;
  assign pd_keep       = keep_c;
  assign pd_last       = last_c;
  assign done_err      = err;
  assign done_ret_head = hdr.ret_head;
  assign done_ret_qmgr = hdr.ret_qmgr;
  assign done_ret_qnum = hdr.ret_qnum;
endmodule

// File: rtl/mde_checker.sv
module mde_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ps_valid,
  input logic        ps_ready,
  input logic [31:0] ps_data,
  input logic        pd_valid,
  input logic        pd_ready,
  input logic [31:0] pd_data,
  input logic [3:0]  pd_keep,
  input logic        pd_last,
  input logic        mem_rd_en,
  input logic        done_valid,
  input logic [2:0]  done_err
);
  assert_ps_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ps_valid && !ps_ready |=> ps_valid && $stable(ps_data));

  assert_pd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pd_valid && !pd_ready |=> pd_valid && $stable(pd_data) && $stable(pd_keep) && $stable(pd_last));

  assert_read_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_valid || pd_valid) |-> !mem_rd_en);

  assert_streams_apart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ps_valid && pd_valid));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  assert_keep_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pd_valid && !pd_last |-> pd_keep == 4'b1111);

  assert_keep_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pd_valid |-> (pd_keep == 4'b0001 || pd_keep == 4'b0011 || pd_keep == 4'b0111 || pd_keep == 4'b1111));

  assert_err_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_err != 3'd0 |-> !$past(ps_valid) && !$past(pd_valid));
endmodule

bind mono_desc_extract mde_checker u_mde_chk (
  .clk(clk), .rst_n(rst_n),
  .ps_valid(ps_valid), .ps_ready(ps_ready), .ps_data(ps_data),
  .pd_valid(pd_valid), .pd_ready(pd_ready), .pd_data(pd_data),
  .pd_keep(pd_keep), .pd_last(pd_last), .mem_rd_en(mem_rd_en),
  .done_valid(done_valid), .done_err(done_err)
);

// File: tb/mono_desc_extract_bench.sv
module mono_desc_extract_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 10;
  localparam int MEM_WORDS  = 1024;
  localparam int NV         = 14;

  typedef struct packed {
    logic [9:0]  base;
    logic [1:0]  kind;
    logic        ext;
    logic [5:0]  cnt;
    logic [8:0]  off;
    logic [15:0] len;
    logic [14:0] ret;
    logic [1:0]  mode;
    logic [2:0]  err;
  } vec_t;

  // base, kind, ext, count, offset, length, return, ready mode, expected error
  localparam vec_t VECS [NV] = '{
    '{10'd0,   2'd2, 1'b0, 6'd0,  9'd12,  16'd8,     15'h0123, 2'd0, 3'd0},
    '{10'd64,  2'd2, 1'b1, 6'd2,  9'd40,  16'd5,     15'h4abc, 2'd1, 3'd0},
    '{10'd128, 2'd2, 1'b0, 6'd1,  9'd17,  16'd7,     15'h1005, 2'd2, 3'd0},
    '{10'd192, 2'd2, 1'b1, 6'd0,  9'd35,  16'd10,    15'h7fff, 2'd1, 3'd0},
    '{10'd256, 2'd2, 1'b0, 6'd0,  9'd14,  16'd0,     15'h2222, 2'd0, 3'd0},
    '{10'd320, 2'd1, 1'b0, 6'd0,  9'd12,  16'd8,     15'h0001, 2'd0, 3'd1},
    '{10'd384, 2'd2, 1'b0, 6'd33, 9'd200, 16'd4,     15'h0002, 2'd0, 3'd2},
    '{10'd448, 2'd2, 1'b1, 6'd0,  9'd20,  16'd4,     15'h0003, 2'd0, 3'd3},
    '{10'd512, 2'd2, 1'b0, 6'd4,  9'd24,  16'd4,     15'h0004, 2'd0, 3'd3},
    '{10'd576, 2'd2, 1'b0, 6'd0,  9'd12,  16'd1013,  15'h0005, 2'd0, 3'd4},
    '{10'd700, 2'd2, 1'b0, 6'd0,  9'd12,  16'd1012,  15'h6006, 2'd2, 3'd0},
    '{10'd640, 2'd0, 1'b0, 6'd40, 9'd12,  16'd4,     15'h0007, 2'd0, 3'd1},
    '{10'd660, 2'd2, 1'b0, 6'd33, 9'd0,   16'd65535, 15'h0008, 2'd0, 3'd2},
    '{10'd960, 2'd2, 1'b1, 6'd32, 9'd160, 16'd6,     15'h3456, 2'd1, 3'd0}
  };

  logic              clk, rst_n, start;
  logic [ADDR_W-1:0] start_addr, mem_addr;
  logic              mem_rd_en;
  logic [31:0]       mem_rd_data;
  logic              ps_valid, ps_ready, pd_valid, pd_ready, pd_last, done_valid;
  logic [31:0]       ps_data, pd_data;
  logic [3:0]        pd_keep;
  logic [2:0]        done_err;
  logic              done_ret_head;
  logic [1:0]        done_ret_qmgr;
  logic [11:0]       done_ret_qnum;

  logic [31:0] mem [MEM_WORDS];
  int n_checks, n_fail;
  int pad_hits;
  logic [ADDR_W-1:0] pad_addr;
  logic pad_watch;

  mono_desc_extract u_mono_desc_extract (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
    .ps_valid(ps_valid), .ps_ready(ps_ready), .ps_data(ps_data),
    .pd_valid(pd_valid), .pd_ready(pd_ready), .pd_data(pd_data),
    .pd_keep(pd_keep), .pd_last(pd_last), .done_valid(done_valid),
    .done_err(done_err), .done_ret_head(done_ret_head),
    .done_ret_qmgr(done_ret_qmgr), .done_ret_qnum(done_ret_qnum)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem[mem_addr];
    if (mem_rd_en && pad_watch && mem_addr == pad_addr) pad_hits <= pad_hits + 1;
  end

  function automatic logic [7:0] pbyte(int unsigned a);
    return 8'((a * 7 + 3) ^ (a >> 5));
  endfunction

  function automatic logic [7:0] mbyte(int unsigned a);
    return mem[a >> 2][8 * (a % 4) +: 8];
  endfunction

  task automatic check(bit ok, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic run_vec(int i);
    vec_t v;
    int unsigned exp_ps, exp_beats, first;
    int ps_n, pd_n, ps_bad, byte_bad, kl_bad, hold_bad, rd_bad, order_bad;
    bit got_done, held, r;
    logic [31:0] held_data;
    logic [2:0] got_err;
    logic [14:0] got_ret;
    v = VECS[i];
    mem[v.base]     = {v.kind, 5'd0, v.off, v.len};
    mem[v.base + 1] = 32'hA5A5_0000 | 32'(i);
    mem[v.base + 2] = {v.ext, 1'b0, v.cnt, 8'h00, 1'b0, v.ret};
    exp_ps    = (v.err == 3'd0) ? 32'(v.cnt) : 0;
    exp_beats = (v.err == 3'd0) ? (32'(v.len) + 3) / 4 : 0;
    first     = v.ext ? 8 : 3;
    ps_n = 0; pd_n = 0; ps_bad = 0; byte_bad = 0; kl_bad = 0;
    hold_bad = 0; rd_bad = 0; order_bad = 0; got_done = 0; held = 0;
    held_data = '0; got_err = '0; got_ret = '0;
    pad_addr = v.base + 10'd3; pad_watch = v.ext; pad_hits = 0;
    @(negedge clk);
    start = 1'b1; start_addr = v.base;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 4000 && !got_done; c++) begin
      r = (v.mode == 2'd0) ? 1'b1 : (v.mode == 2'd1) ? c[0] : (c % 3 == 2);
      ps_ready = r; pd_ready = r;
      #1;
      if (held && (!pd_valid || pd_data != held_data)) hold_bad++;
      held = 0;
      if (pd_valid && !pd_ready) begin held = 1; held_data = pd_data; end
      if ((pd_valid || ps_valid) && mem_rd_en) rd_bad++;
      if (ps_valid && ps_ready) begin
        if (ps_n >= int'(exp_ps) || ps_data != mem[32'(v.base) + first + 32'(ps_n)]) ps_bad++;
        if (pd_n > 0) order_bad++;
        ps_n++;
      end
      if (pd_valid && pd_ready) begin
        int unsigned rem;
        logic [3:0] ek;
        for (int j = 0; j < 4; j++) begin
          int unsigned k;
          k = 4 * pd_n + j;
          if (k < 32'(v.len) && pd_data[8*j +: 8] != mbyte(4 * 32'(v.base) + 32'(v.off) + k)) byte_bad++;
        end
        rem = 32'(v.len) - 4 * pd_n;
        ek  = (rem >= 4) ? 4'hF : 4'((1 << rem) - 1);
        if (pd_keep != ek || pd_last != (pd_n == int'(exp_beats) - 1)) kl_bad++;
        pd_n++;
      end
      if (done_valid) begin
        got_done = 1; got_err = done_err;
        got_ret = {done_ret_head, done_ret_qmgr, done_ret_qnum};
      end
      @(negedge clk);
    end
    check(got_done, $sformatf("watchdog vec%0d done_valid", i), 0, 1);
    case (v.err)
      3'd1: check(got_err == v.err, $sformatf("R1 vec%0d error code", i), got_err, v.err);
      3'd2: check(got_err == v.err, $sformatf("R2 vec%0d error code", i), got_err, v.err);
      3'd3: check(got_err == v.err, $sformatf("R3 vec%0d error code", i), got_err, v.err);
      3'd4: check(got_err == v.err, $sformatf("R4 vec%0d error code", i), got_err, v.err);
      default: check(got_err == v.err, $sformatf("R6 vec%0d clean error code", i), got_err, v.err);
    endcase
    check(got_ret == v.ret, $sformatf("R10 vec%0d return info", i), got_ret, v.ret);
    check(ps_n == int'(exp_ps), $sformatf("R5 vec%0d sideband count", i), ps_n, exp_ps);
    check(ps_bad == 0, $sformatf("R5 vec%0d sideband words wrong", i), ps_bad, 0);
    if (v.ext) check(pad_hits == 0, $sformatf("R5 vec%0d pad word reads", i), pad_hits, 0);
    check(pd_n == int'(exp_beats), $sformatf("R6 vec%0d payload beats", i), pd_n, exp_beats);
    check(byte_bad == 0, $sformatf("R6 vec%0d payload bytes wrong", i), byte_bad, 0);
    check(kl_bad == 0, $sformatf("R7 vec%0d keep/last wrong", i), kl_bad, 0);
    if (v.err == 3'd0 && v.len == 16'd0)
      check(pd_n == 0 && got_err == 3'd0, $sformatf("R8 vec%0d zero-length beats", i), pd_n, 0);
    check(hold_bad == 0 && rd_bad == 0, $sformatf("R9 vec%0d stall hold/read", i), hold_bad + rd_bad, 0);
    check(order_bad == 0, $sformatf("R11 vec%0d sideband after payload", i), order_bad, 0);
  endtask

  initial begin
    n_checks = 0; n_fail = 0;
    start = 1'b0; start_addr = '0; ps_ready = 1'b0; pd_ready = 1'b0;
    pad_watch = 1'b0; pad_addr = '0; pad_hits = 0; mem_rd_data = '0;
    for (int w = 0; w < MEM_WORDS; w++)
      mem[w] = {pbyte(4*w+3), pbyte(4*w+2), pbyte(4*w+1), pbyte(4*w)};
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    // R12: quiet outputs in reset
    check(!ps_valid && !pd_valid && !done_valid && !mem_rd_en, "R12 outputs in reset",
          {ps_valid, pd_valid, done_valid, mem_rd_en}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(!ps_valid && !pd_valid && !done_valid && !mem_rd_en, "R12 idle after reset",
          {ps_valid, pd_valid, done_valid, mem_rd_en}, 0);
    for (int i = 0; i < NV; i++) run_vec(i);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule